// File: doc/BRIEF.md
# Linear Chirp Phase-Accumulator Generator

This block synthesises a linear frequency sweep (a chirp) as a stream of signed cosine samples. Two accumulators are kept. A phase word indexes a cosine table. A frequency word is added to the phase after each sample, and a fixed step is then added to the frequency word. Because the frequency itself is integrated, the phase is a quadratic function of the sample number and the output frequency rises linearly over the sweep.

Software or an upstream sequencer supplies a start frequency word, a per-sample frequency step and a sweep length in samples, then pulses start. A sample-enable input paces the sweep, so the sample rate can be any fraction of the clock. Each accepted sample produces a one-cycle valid strobe with the table value. A one-cycle done pulse follows the last sample. Converting hertz values into the start word and the step is left to the caller.

Phase and frequency use a fixed-point format with `IDX_W` integer bits (the table index) and `FRAC_W` fractional bits. The index is rounded to the nearest table entry, not truncated. The table covers one full cosine period. By default it is stored as a quarter wave and unfolded by symmetry.

Top module: `chirp_sweep_gen`

## Requirements
- R1: While reset is held, and after it until the first sample, `sample_o`, `valid_o` and `done_o` are all zero.
- R2: A start pulse clears the phase to 0, loads the frequency word with `start_freq_i` and latches the step and the length. The first sample of every sweep is therefore the table value at index 0, which is +127.
- R3: Sample k (counting from 0) is taken at phase P(k) = (k·S + T·k·(k−1)/2) mod 2^23, where S is the start word and T is the step. The phase addition wraps modulo 2^23.
- R4: The table index is ((P + 1024) >> 11) mod 4096, which rounds the phase to the nearest entry.
- R5: The entry at index i is round(127·cos(2π·i/4096)). It is output as an 8-bit two's-complement value.
- R6: `valid_o` pulses one clock after each clock in which a sweep is running, `sample_en_i` is high and `start_i` is low. A sweep yields exactly the programmed number of samples.
- R7: `done_o` is high for exactly one clock, in the clock after the last sample's `valid_o`.
- R8: While `sample_en_i` is low, neither the phase nor the frequency changes and no sample is produced.
- R9: A start pulse during a running sweep abandons it, with no done pulse, and begins a new sweep from R2.
- R10: The frequency accumulator is wide enough that it never wraps over a sweep of any programmable length. Only its low 23 bits enter the phase sum, so frequency words of 2^23 or more alias.
- R11: A programmed length of 0 produces no samples. `done_o` pulses two clocks after the start pulse.
- R12: Changes on `start_freq_i`, `freq_step_i` and `sweep_len_i` after the start pulse have no effect on the running sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start (or restart) pulse |
| sample_en_i | input | 1 | Sample-rate enable |
| start_freq_i | input | 23 | Start frequency word, 12.11 fixed point |
| freq_step_i | input | 23 | Frequency increment per sample, 12.11 fixed point |
| sweep_len_i | input | 12 | Sweep length in samples |
| sample_o | output | 8 | Signed cosine sample |
| valid_o | output | 1 | Sample strobe |
| done_o | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The bench builds the block with its defaults: a 12-bit table index, 11 fractional bits, an 8-bit output, a 12-bit length and the quarter-wave table. These widths allow a full 2048-sample sweep, with the quadratic term reaching about 2^42 before the modulo. A start word near 2^23 with a step of 2^21 pushes the frequency word past 2^23, so aliasing and phase wrap are both exercised. Half-entry start words expose round-versus-truncate errors in the index, and phases that land on quadrant edges check the quarter-wave unfolding.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

  typedef enum logic [1:0] {
    QD_FIRST  = 2'd0,
    QD_SECOND = 2'd1,
    QD_THIRD  = 2'd2,
    QD_FOURTH = 2'd3
  } quadrant_e;

  localparam real TWO_PI = 6.283185307179586;

  // Round a real to the nearest integer, halves away from zero.
  function automatic int round_real(input real v);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(0.5 - v);
  endfunction

  // Signed table code for entry k of a period of 2^idx_w entries.
  function automatic int cos_code(input int k, input int idx_w, input int out_w);
    real amp;
    real ang;
    amp = real'((1 << (out_w - 1)) - 1);
    ang = TWO_PI * real'(k) / real'(1 << idx_w);
    return round_real(amp * $cos(ang));
  endfunction

  // Nearest-entry index of a ph_w-bit phase with frac_w fractional bits.
  function automatic logic [63:0] round_index(input logic [63:0] ph,
                                              input int ph_w,
                                              input int frac_w);
    logic [63:0] mask;
    logic [63:0] sum;
    mask = (64'd1 << ph_w) - 64'd1;
    sum  = (ph + (64'd1 << (frac_w - 1))) & mask;
    return sum >> frac_w;
  endfunction

  // Frequency after one step, in a width that cannot wrap.
  function automatic logic [63:0] freq_next(input logic [63:0] f,
                                            input logic [63:0] step);
    return f + step;
  endfunction

endpackage

// File: rtl/chirp_accum.sv
module chirp_accum
  import chirp_pkg::*;
#(
  parameter int IDX_W  = 12,
  parameter int FRAC_W = 11,
  parameter int FREQ_W = 36,
  localparam int PH_W  = IDX_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [PH_W-1:0]   start_freq_i,
  input  logic [PH_W-1:0]   freq_step_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [PH_W-1:0]   phase_q;
  logic [FREQ_W-1:0] freq_q;
  logic [PH_W-1:0]   step_q;
  logic [PH_W-1:0]   phase_d;
  logic [FREQ_W-1:0] freq_d;
  logic [63:0]       idx_wide;
  logic [63:0]       freq_wide;

  always_comb begin
    phase_d   = phase_q + freq_q[PH_W-1:0];
    freq_wide = freq_next(64'(freq_q), 64'(step_q));
    freq_d    = freq_wide[FREQ_W-1:0];
    idx_wide  = round_index(64'(phase_q), PH_W, FRAC_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      freq_q  <= '0;
      step_q  <= '0;
    end else if (load_i) begin
      phase_q <= '0;
      freq_q  <= FREQ_W'(start_freq_i);
      step_q  <= freq_step_i;
    end else if (adv_i) begin
      phase_q <= phase_d;
      freq_q  <= freq_d;
    end
  end

  assign phase_o = phase_q;
  assign freq_o  = freq_q;
  assign idx_o   = idx_wide[IDX_W-1:0];

endmodule

// File: rtl/chirp_ctrl.sv
module chirp_ctrl #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sample_en_i,
  input  logic [LEN_W-1:0] sweep_len_i,
  output logic             load_o,
  output logic             fire_o,
  output logic             busy_o,
  output logic             valid_o,
  output logic             done_o
);

  logic             busy_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic             fin_q;
  logic             valid_q;
  logic             done_q;
  logic             fire;
  logic             last;
  logic             len_zero;

  always_comb begin
    fire     = busy_q && sample_en_i && !start_i;
    last     = (cnt_q == len_q - LEN_W'(1));
    len_zero = (sweep_len_i == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      len_q   <= '0;
      cnt_q   <= '0;
      fin_q   <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      done_q  <= fin_q && !start_i;
      if (start_i) begin
        busy_q <= !len_zero;
        len_q  <= sweep_len_i;
        cnt_q  <= '0;
        fin_q  <= len_zero;
      end else begin
        fin_q <= fire && last;
        if (fire) begin
          cnt_q <= cnt_q + LEN_W'(1);
          if (last) busy_q <= 1'b0;
        end
      end
    end
  end

  assign load_o  = start_i;
  assign fire_o  = fire;
  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;

endmodule

// File: rtl/chirp_cos_rom.sv
module chirp_cos_rom
  import chirp_pkg::*;
#(
  parameter int IDX_W   = 12,
  parameter int OUT_W   = 8,
  parameter bit QUARTER = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [OUT_W-1:0] sample_o
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int QSPAN = DEPTH / 4;

  logic signed [OUT_W-1:0] lut_val;
  logic signed [OUT_W-1:0] sample_q;

  generate
    if (QUARTER) begin : g_quarter
      logic signed [OUT_W-1:0] qtab [QSPAN+1];
      quadrant_e               quad;
      logic [IDX_W-3:0]        rem;
      logic [IDX_W-2:0]        addr;
      logic signed [OUT_W-1:0] entry;
      logic                    mirror;
      logic                    negate;

      initial begin
        for (int k = 0; k <= QSPAN; k++) begin
          qtab[k] = OUT_W'(cos_code(k, IDX_W, OUT_W));
        end
      end

      always_comb begin
        quad   = quadrant_e'(idx_i[IDX_W-1 -: 2]);
        rem    = idx_i[IDX_W-3:0];
        mirror = (quad == QD_SECOND) || (quad == QD_FOURTH);
        negate = (quad == QD_SECOND) || (quad == QD_THIRD);
        addr   = mirror ? (IDX_W-1)'(QSPAN) - {1'b0, rem} : {1'b0, rem};
        entry  = qtab[addr];
        lut_val = negate ? -entry : entry;
      end
    end else begin : g_full
      logic signed [OUT_W-1:0] ftab [DEPTH];

      initial begin
        for (int k = 0; k < DEPTH; k++) begin
          ftab[k] = OUT_W'(cos_code(k, IDX_W, OUT_W));
        end
      end

      always_comb lut_val = ftab[idx_i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)    sample_q <= '0;
    else if (en_i) sample_q <= lut_val;
  end

  assign sample_o = sample_q;

endmodule

// File: rtl/chirp_sweep_gen.sv
module chirp_sweep_gen #(
  parameter int IDX_W   = 12,
  parameter int FRAC_W  = 11,
  parameter int OUT_W   = 8,
  parameter int LEN_W   = 12,
  parameter bit QUARTER = 1'b1,
  localparam int PH_W   = IDX_W + FRAC_W,
  localparam int FREQ_W = PH_W + LEN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    sample_en_i,
  input  logic [PH_W-1:0]         start_freq_i,
  input  logic [PH_W-1:0]         freq_step_i,
  input  logic [LEN_W-1:0]        sweep_len_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o,
  output logic                    done_o
);

  logic              load_w;
  logic              fire_w;
  logic              busy_w;
  logic [PH_W-1:0]   phase_w;
  logic [FREQ_W-1:0] freq_w;
  logic [IDX_W-1:0]  idx_w;

  chirp_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .sample_en_i(sample_en_i),
    .sweep_len_i(sweep_len_i),
    .load_o     (load_w),
    .fire_o     (fire_w),
    .busy_o     (busy_w),
    .valid_o    (valid_o),
    .done_o     (done_o)
  );

  chirp_accum #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .FREQ_W(FREQ_W)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_w),
    .adv_i       (fire_w),
    .start_freq_i(start_freq_i),
    .freq_step_i (freq_step_i),
    .phase_o     (phase_w),
    .freq_o      (freq_w),
    .idx_o       (idx_w)
  );

  chirp_cos_rom #(.IDX_W(IDX_W), .OUT_W(OUT_W), .QUARTER(QUARTER)) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (fire_w),
    .idx_i   (idx_w),
    .sample_o(sample_o)
  );

endmodule

// File: rtl/chirp_sweep_checker.sv
module chirp_sweep_checker #(
  parameter int PH_W   = 23,
  parameter int FREQ_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [PH_W-1:0]   start_freq_i,
  input logic              fire,
  input logic              busy,
  input logic              valid_o,
  input logic              done_o,
  input logic [PH_W-1:0]   phase,
  input logic [FREQ_W-1:0] freq
);

  // R2: start clears phase and loads the start word
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (phase == '0) && (freq == FREQ_W'($past(start_freq_i))));

  // R3: phase advances by the low part of the frequency, modulo 2^PH_W
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> phase == PH_W'($past(phase) + $past(freq[PH_W-1:0])));

  // R10: the frequency word never wraps
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> freq >= $past(freq));

  // R8: without an accepted sample the accumulators hold
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !start_i) |=> $stable(phase) && $stable(freq));

  // R6: every strobe comes from an accepted sample
  a_r6_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(fire));

  // R7: done lasts one cycle and only when idle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);

endmodule

bind chirp_sweep_gen chirp_sweep_checker #(.PH_W(PH_W), .FREQ_W(FREQ_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_freq_i(start_freq_i),
  .fire        (fire_w),
  .busy        (busy_w),
  .valid_o     (valid_o),
  .done_o      (done_o),
  .phase       (phase_w),
  .freq        (freq_w)
);

// File: tb/test_chirp_sweep_gen.sv
`timescale 1ns/1ps
module test_chirp_sweep_gen;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              sample_en_i = 1'b0;
  logic [22:0]       start_freq_i = '0;
  logic [22:0]       freq_step_i = '0;
  logic [11:0]       sweep_len_i = '0;
  logic signed [7:0] sample_o;
  logic              valid_o;
  logic              done_o;

  chirp_sweep_gen i_chirp_sweep_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sample_en_i(sample_en_i),
    .start_freq_i(start_freq_i), .freq_step_i(freq_step_i),
    .sweep_len_i(sweep_len_i), .sample_o(sample_o), .valid_o(valid_o),
    .done_o(done_o)
  );

  always #10 clk = ~clk;

  int     nchk = 0;
  int     nerr = 0;
  longint cyc = 0;
  longint m_s = 0, m_t = 0, m_len = 0, k = 0;
  int     done_cnt = 0, extra = 0;
  longint last_valid_cyc = 0, done_cyc = 0, start_cyc = 0;
  string  m_req = "R3";

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_sample(input longint n);
    longint ph, idx;
    real v;
    ph  = (n * m_s + m_t * ((n * (n - 1)) / 2)) & 64'h7FFFFF;        // R3
    idx = ((ph + 1024) >> 11) & 4095;                                // R4
    v   = 127.0 * $cos(6.283185307179586 * real'(idx) / 4096.0);     // R5
    return (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(0.5 - v));
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (rst_n && valid_o) begin
      if (k >= m_len) extra++;
      else chk(m_req, longint'(sample_o), exp_sample(k), $sformatf("sample %0d", k));
      k++;
      last_valid_cyc = cyc;
    end
    if (rst_n && done_o) begin
      done_cnt++;
      done_cyc = cyc;
    end
  end

  task automatic begin_sweep(input longint s, input longint t, input longint len);
    @(negedge clk);
    start_freq_i = 23'(s);
    freq_step_i  = 23'(t);
    sweep_len_i  = 12'(len);
    start_i      = 1'b1;
    @(posedge clk);
    #1;
    m_s = s; m_t = t; m_len = len; k = 0;
    done_cnt = 0; extra = 0; start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finish_sweep(input string tag, input int period, input bit scramble);
    int c = 0;
    int guard = 0;
    if (scramble) begin   // R12: inputs move after start
      start_freq_i = 23'h5A5A5; freq_step_i = 23'h12345; sweep_len_i = 12'd7;
    end
    while (done_cnt == 0 && guard < 30000) begin
      sample_en_i = (c % period == 0);
      c++; guard++;
      @(negedge clk);
    end
    sample_en_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(tag, k, m_len, "R6 sample count");
    chk(tag, done_cnt, 1, "R7 done pulses");
    chk(tag, done_cyc, last_valid_cyc + 1, "R7 done cycle");
    chk(tag, extra, 0, "R6 extra strobes");
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", sample_o, 0, "sample in reset");
    chk("R1", valid_o, 0, "valid in reset");
    chk("R1", done_o, 0, "done in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {valid_o, done_o}, 0, "idle after reset");
  endtask

  task automatic t_basic;                       // R2 R3 R4 R5 R6 R7
    m_req = "R3";
    begin_sweep(174763, 768, 2048);
    finish_sweep("R3", 1, 1'b0);
  endtask

  task automatic t_quadrants;                   // R5: +127, 0, -127, 0
    m_req = "R5";
    begin_sweep(2097152, 0, 8);
    finish_sweep("R5", 1, 1'b0);
  endtask

  task automatic t_rounding;                    // R4: half-entry phases
    m_req = "R4";
    begin_sweep(37 * 2048 + 1536, 0, 300);
    finish_sweep("R4", 1, 1'b0);
  endtask

  task automatic t_wrap;                        // R10 aliasing, R3 wrap
    m_req = "R10";
    begin_sweep(8388608 - 5000, 2097152, 40);
    finish_sweep("R10", 1, 1'b0);
  endtask

  task automatic t_gated;                       // R8 hold, R12 ignored inputs
    m_req = "R8";
    begin_sweep(40000, 3000, 60);
    sample_en_i = 1'b0;
    repeat (15) @(negedge clk);
    chk("R8", k, 0, "no samples while disabled");
    finish_sweep("R12", 3, 1'b1);
  endtask

  task automatic t_restart;                     // R9
    int guard = 0;
    m_req = "R9";
    begin_sweep(100000, 500, 200);
    sample_en_i = 1'b1;
    while (k < 30 && guard < 1000) begin
      guard++;
      @(negedge clk);
    end
    begin_sweep(250000, 1200, 90);
    chk("R9", done_cnt, 0, "no done from abandoned sweep");
    finish_sweep("R9", 1, 1'b0);
  endtask

  task automatic t_len0;                        // R11
    m_req = "R11";
    sample_en_i = 1'b1;
    begin_sweep(1000, 10, 0);
    repeat (4) @(negedge clk);
    sample_en_i = 1'b0;
    chk("R11", k + extra, 0, "samples for zero length");
    chk("R11", done_cnt, 1, "done pulses");
    chk("R11", done_cyc, start_cyc + 2, "done cycle");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_quadrants();
    t_rounding();
    t_wrap();
    t_gated();
    t_restart();
    t_len0();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule